// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block turns the outputs of two interval-timer channels, called channel 0 and channel 2, into one level-sensitive CPU interrupt request. Each timer output goes through a synchronizer and a rising-edge detector. A detected rising edge latches that channel's status bit. The request line stays high while any status bit is set and its channel is enabled.

Software reaches the block through a simple synchronous port with an address, a write strobe, write data, a read strobe and read data. The enable bits cannot be loaded with a value. A write to one fixed address inverts the channel 0 enable, and a write to a second fixed address inverts the channel 2 enable. The value on the data bus plays no part in either write. A read from the status address has no side effects. A read from the second address returns the same word and then clears both status bits at once.

Timer outputs must stay high, and then low, for at least as many clock cycles as the synchronizer has stages plus one. Narrower pulses are not supported.

Top module: `tic_top`

## Requirements
- R1: After reset, both enable bits, both status bits, `irq` and `bus_rdata` are zero.
- R2: A read strobe at address 0x4010 loads `bus_rdata` at the next clock edge with the register word and has no side effects. In that word, bit 0 is the channel 0 status, bit 1 is the channel 2 status, bit 4 is the channel 0 enable and bit 5 is the channel 2 enable. All other bits are zero. A read at any address other than 0x4010 or 0x4014 loads zero.
- R3: Every write strobe at address 0x4010 inverts the channel 0 enable (bit 4), whatever the write data.
- R4: Every write strobe at address 0x4014 inverts the channel 2 enable (bit 5), whatever the write data.
- R5: A write strobe at any other address changes neither enable bit nor either status bit.
- R6: A low-to-high change on a timer input sets that channel's status bit at the third rising clock edge after the input goes high (two synchronizer stages plus the edge register). The status bit is set whether or not the channel is enabled. An input held high sets the bit only once.
- R7: A status bit stays set until a read strobe at 0x4014. That read returns the register word as it was before the read, then clears both status bits at the same edge.
- R8: If a detected edge and a clearing read fall on the same clock edge, that channel's status bit stays set.
- R9: `irq` is high exactly when (status bit 0 AND enable bit 4) OR (status bit 1 AND enable bit 5), and it follows those register bits with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr0_out | input | 1 | Output of timer channel 0, asynchronous |
| tmr2_out | input | 1 | Output of timer channel 2, asynchronous |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W (32) | Write data, ignored by both toggle writes |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 32-bit data word and a two-stage synchronizer. The full 16-bit address compare lets the bench write to near-miss addresses such as 0x4011, 0x4018 and 0xC010 and show that they toggle nothing. The 32-bit read word shows that the upper bits stay zero. The two-stage synchronizer fixes the set latency at three edges, so the bench can watch `irq` at the edge just before and the edge just after a status bit sets. It can also place a clearing read on exactly the edge where a pending rising edge lands.

// File: rtl/tic_pkg.sv
package tic_pkg;
  // Bit positions inside the register word. Software decodes these.
  localparam int unsigned ST0_POS = 0;
  localparam int unsigned ST2_POS = 1;
  localparam int unsigned EN0_POS = 4;
  localparam int unsigned EN2_POS = 5;
  localparam int unsigned NCH     = 2;  // index 0 = timer channel 0, index 1 = timer channel 2

  typedef struct packed {
    logic [NCH-1:0] en;
    logic [NCH-1:0] st;
  } tic_state_t;

  // Interrupt request: any channel that has both its status and its enable set.
  function automatic logic irq_of(tic_state_t s);
    return |(s.st & s.en);
  endfunction
endpackage

// File: rtl/tic_edge_det.sv
module tic_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[MSB];

  assign rise = sync_q[MSB] & ~prev_q;

  // A held level yields a single pulse.
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tic_bus_dec.sv
module tic_bus_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h4010,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h4014
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [1:0]        tog,      // [0] channel 0, [1] channel 2
  output logic              clr_req,
  output logic              word_rd
);
  logic hit_stat, hit_clr;

  assign hit_stat = (addr == STAT_ADDR);
  assign hit_clr  = (addr == CLR_ADDR);

  assign tog[0]  = wr & hit_stat;
  assign tog[1]  = wr & hit_clr;
  assign clr_req = rd & hit_clr;
  assign word_rd = rd & (hit_stat | hit_clr);
endmodule

// File: rtl/tic_regs.sv
module tic_regs
  import tic_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise,
  input  logic [NCH-1:0] tog,
  input  logic           clr_req,
  output tic_state_t     state
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state.st[c] <= 1'b0;
          state.en[c] <= 1'b0;
        end else begin
          // A set beats the clear in the same cycle.
          if (rise[c])      state.st[c] <= 1'b1;
          else if (clr_req) state.st[c] <= 1'b0;
          if (tog[c])       state.en[c] <= ~state.en[c];
        end
      end
    end
  endgenerate

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((state.st & $past(rise)) == $past(rise)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && rise == '0) |=> (state.st == '0));
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && rise[0]) |=> state.st[0]);
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tog[0] |=> (state.en[0] != $past(state.en[0])));
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tog[1] |=> (state.en[1] != $past(state.en[1])));
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tog == '0) |=> $stable(state.en));
endmodule

// File: rtl/tic_top.sv
module tic_top
  import tic_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h4010,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h4014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr0_out,
  input  logic              tmr2_out,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NCH-1:0] tmr_in, rise, tog;
  logic           clr_req, word_rd;
  tic_state_t     state;

  assign tmr_in = {tmr2_out, tmr0_out};

  function automatic logic [DATA_W-1:0] pack_word(tic_state_t s);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[ST0_POS] = s.st[0];
    w[ST2_POS] = s.st[1];
    w[EN0_POS] = s.en[0];
    w[EN2_POS] = s.en[1];
    return w;
  endfunction

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_det
      tic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk (clk), .rst_n(rst_n), .din(tmr_in[c]), .rise(rise[c]));
    end
  endgenerate

  tic_bus_dec #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .tog(tog), .clr_req(clr_req), .word_rd(word_rd));

  tic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rise(rise), .tog(tog),
    .clr_req(clr_req), .state(state));

  // The read word is captured before the clear takes effect.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= word_rd ? pack_word(state) : '0;

  assign irq = irq_of(state);

  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state.en == '0) |-> !irq);
  assert_irq_needs_st_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state.st == '0) |-> !irq);
  assert_read_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !clr_req) |=> $stable(state.st) || ($past(rise) != '0));
  assert_rdata_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~pack_word('1)) == '0);
endmodule

// File: tb/tic_top_tb.sv
`timescale 1ns/1ps
module tic_top_tb;
  localparam logic [15:0] A_STAT = 16'h4010;
  localparam logic [15:0] A_CLR  = 16'h4014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr0_out = 1'b0, tmr2_out = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [1:0] m_st = '0, m_en = '0;   // bench model, [0] channel 0, [1] channel 2

  always #2.5 clk = ~clk;

  tic_top u_dut (
    .clk(clk), .rst_n(rst_n), .tmr0_out(tmr0_out), .tmr2_out(tmr2_out),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] word_exp(logic [1:0] st, logic [1:0] en);
    return (32'(st[0]) << 0) | (32'(st[1]) << 1) | (32'(en[0]) << 4) | (32'(en[1]) << 5);
  endfunction

  function automatic logic irq_exp(logic [1:0] st, logic [1:0] en);
    return (st[0] && en[0]) || (st[1] && en[1]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic set_tmr(int ch, logic v);
    if (ch == 0) tmr0_out = v; else tmr2_out = v;
  endtask

  task automatic pulse(int ch);
    @(negedge clk); set_tmr(ch, 1'b1);
    repeat (4) @(negedge clk);
    set_tmr(ch, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_word(string req);
    logic [31:0] v;
    bus_read(A_STAT, v);
    chk(req, v, word_exp(m_st, m_en));
    chk("R9", 32'(irq), 32'(irq_exp(m_st, m_en)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    check_word("R1 word");

    // R3/R4 toggles with varied data
    bus_write(A_STAT, 32'h0);        m_en[0] = ~m_en[0]; check_word("R3 toggle zero data");
    bus_write(A_STAT, 32'hFFFF_FFFF); m_en[0] = ~m_en[0]; check_word("R3 toggle ones data");
    bus_write(A_CLR, 32'h0000_0020); m_en[1] = ~m_en[1]; check_word("R4 toggle");
    // R5 near-miss addresses
    bus_write(16'h4011, 32'h30); bus_write(16'h4018, 32'h30); bus_write(16'hC010, 32'h30);
    check_word("R5 near miss");
    // R2 read elsewhere returns zero
    bus_read(16'h4000, v); chk("R2 other addr", v, 32'h0);

    // R6 latency, status set while disabled, irq gated
    m_en = 2'b10; // channel 2 on, channel 0 off
    @(negedge clk); tmr0_out = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 disabled ch0 no irq", 32'(irq), 32'h0);
    m_st[0] = 1'b1; check_word("R6 set while disabled");
    // R6 latency at irq via channel 2
    @(negedge clk); tmr2_out = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet set", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R6 set third edge", 32'(irq), 32'h1);
    m_st[1] = 1'b1;
    // R7 clearing read returns pre-clear word, then both clear; level held does not retrigger
    bus_read(A_CLR, v); chk("R7 pre-clear word", v, word_exp(m_st, m_en));
    m_st = '0;
    repeat (6) @(negedge clk);
    check_word("R7 cleared, no retrigger");
    tmr0_out = 1'b0; tmr2_out = 1'b0;
    repeat (4) @(negedge clk);

    // R8 edge meets clearing read; channel 2 set beforehand gets cleared
    pulse(1); m_st[1] = 1'b1;
    @(negedge clk); tmr0_out = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_CLR;
    @(negedge clk); bus_rd = 1'b0;
    chk("R8 read word", bus_rdata, word_exp(m_st, m_en));
    m_st = 2'b01;
    check_word("R8 edge wins");
    tmr0_out = 1'b0; repeat (4) @(negedge clk);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: begin bus_write(A_STAT, $urandom()); m_en[0] = ~m_en[0]; end
        1: begin bus_write(A_CLR, $urandom()); m_en[1] = ~m_en[1]; end
        2: begin
             logic [15:0] a;
             a = 16'($urandom());
             if (a == A_STAT || a == A_CLR) a = 16'h4012;
             bus_write(a, $urandom());
           end
        3: begin bus_read(A_CLR, v); chk("R7 random clear", v, word_exp(m_st, m_en)); m_st = '0; end
        4: begin pulse(0); m_st[0] = 1'b1; end
        5: begin pulse(1); m_st[1] = 1'b1; end
        default: check_word("R2 random read");
      endcase
      chk("R9 random irq", 32'(irq), 32'(irq_exp(m_st, m_en)));
    end
    check_word("R2 final");
    finish_run();
  end
endmodule